// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block gathers event pulses from a bus interface unit's descriptor engines, a level-sensitive interrupt line from an external device and a bus-abort pulse into one sticky status register. Software clears bits by writing ones to them, chooses which sources may interrupt through a per-bit mask, and gates the whole block with a single global enable bit. All sources share one level interrupt output toward the processor. The block also reports which pending source has the lowest bit index, both on output pins and through a read-only register, so a handler can dispatch without scanning the status word.

Access is a simple register port. A write takes effect at the clock edge on which it is presented. A read returns its data one cycle later, marked by a valid strobe. The interrupt output comes from a two-state machine. State `IRQ_QUIET` moves to `IRQ_RAISED` on transition *arm* when any unmasked status bit is set and the enable bit is 1. `IRQ_RAISED` returns to `IRQ_QUIET` on transition *release* once that condition no longer holds. The output is high exactly while the machine is in `IRQ_RAISED`. Every change to the status, mask or enable register therefore reaches the pin one clock later.

Top module: `evt_irq_hub`

## Requirements
- R1: Each event maps to a fixed status bit. The inbound completed, OK, error and end-of-list events (`desc_evt[0..3]`) set bits 0..3. The outbound completed, OK, error and end-of-list events (`desc_evt[4..7]`) set bits 4..7. Inbound out-of-descriptors (`desc_evt[8]`) sets bit 9. `ext_inta` sets bit 25 and `bus_abort` sets bit 26. Set bits stay set until they are cleared.
- R2: Status bits other than 0..7, 9, 25 and 26 always read 0. The mask register keeps only those same bits. The enable register keeps only bit 0.
- R3: Writing the status register (offset 0x500) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event and a clear of the same status bit fall in the same cycle, the event wins and the bit stays 1.
- R5: `ext_inta` is a level input. Its status bit is set again in every cycle that the input stays high, so a clear has no lasting effect while the input is high.
- R6: A source is pending when its status bit and its mask bit (offset 0x504) are both 1. `irq_out` is high only when at least one source is pending and bit 0 of the enable register (offset 0x508) is 1.
- R7: Writing 0 to enable bit 0 drops `irq_out` but leaves the status register unchanged.
- R8: `irq_out` is registered. It follows a change of status, mask or enable one clock edge after the edge that made the change.
- R9: `vec_idx` gives the lowest-numbered pending bit and `vec_valid` is 1 when any source is pending. When nothing is pending, `vec_idx` is 31 and `vec_valid` is 0. The read-only vector register (offset 0x50C) returns the index in bits 4:0 and the valid flag in bit 8.
- R10: A read presented at one clock edge returns its data on `reg_rdata` with `reg_rvalid` high after that edge. The status, mask and enable registers reset to 0. Any other offset reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| desc_evt | input | 9 | Descriptor event pulses, one per source |
| ext_inta | input | 1 | External device interrupt level |
| bus_abort | input | 1 | Bus abort event pulse |
| irq_out | output | 1 | Shared level interrupt to the processor |
| vec_idx | output | 5 | Lowest pending bit index, 31 when none |
| vec_valid | output | 1 | At least one source pending |

## Verification
The hardest case to reach is a status bit being set and cleared in the same cycle. The stimulus presents a clearing write and the matching event pulse on one negative edge, so both land on the same rising edge. The level behaviour of the external line is tested by clearing its bit while `ext_inta` is held high and reading the bit back as still set. A second clear is then issued after the input drops. The stimulus steps the lowest pending bit upward by clearing from the bottom. This drives the vector through bits 3, 9 and 26 and finally into the empty case, where the interrupt must fall one cycle later.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned STAT_W    = 32;
    localparam int unsigned IDX_W     = $clog2(STAT_W);
    localparam int unsigned DESC_N    = 9;
    localparam int unsigned EXT_BIT   = 25;
    localparam int unsigned ABORT_BIT = 26;
    localparam int unsigned VLD_BIT   = 8;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // descriptor event i lands on bit i, except the ninth which skips bit 8
    function automatic int unsigned desc_pos(input int unsigned i);
        return (i < 8) ? i : i + 1;
    endfunction

    function automatic logic [STAT_W-1:0] impl_bits();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < DESC_N; i++) m[desc_pos(i)] = 1'b1;
        m[EXT_BIT]   = 1'b1;
        m[ABORT_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DESC_N-1:0] desc_evt,
    input  logic              ext_inta,
    input  logic              bus_abort,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] status
);

    localparam logic [STAT_W-1:0] IMPL = impl_bits();

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] status_q;

    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < DESC_N; i++) set_vec[desc_pos(i)] = desc_evt[i];
        set_vec[EXT_BIT]   = ext_inta;
        set_vec[ABORT_BIT] = bus_abort;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL;
    end

    assign status = status_q;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    // R2
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~IMPL) == '0);

endmodule

// File: rtl/evt_irq_prio.sv
module evt_irq_prio
    import evt_irq_pkg::*;
(
    input  logic [STAT_W-1:0] pend,
    output logic [IDX_W-1:0]  idx,
    output logic              valid
);

    always_comb begin
        idx = IDX_W'(STAT_W - 1);
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
        valid = |pend;
    end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int unsigned  ADDR_W   = 12,
    parameter logic [11:0]  STAT_OFF = 12'h500,
    parameter logic [11:0]  MASK_OFF = 12'h504,
    parameter logic [11:0]  ENAB_OFF = 12'h508,
    parameter logic [11:0]  VECT_OFF = 12'h50C
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic [8:0]        desc_evt,
    input  logic              ext_inta,
    input  logic              bus_abort,
    output logic              irq_out,
    output logic [4:0]        vec_idx,
    output logic              vec_valid
);

    localparam logic [STAT_W-1:0] IMPL = impl_bits();

    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask_q;
    logic              en_q;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] pend;
    logic              fire;
    irq_state_e        state_q, state_d;
    logic [31:0]       rd_mux;

    wire hit_stat = (reg_addr == ADDR_W'(STAT_OFF));
    wire hit_mask = (reg_addr == ADDR_W'(MASK_OFF));
    wire hit_enab = (reg_addr == ADDR_W'(ENAB_OFF));
    wire hit_vect = (reg_addr == ADDR_W'(VECT_OFF));

    assign clr_vec = (reg_wr_en && hit_stat) ? reg_wdata : '0;

    evt_irq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .desc_evt  (desc_evt),
        .ext_inta  (ext_inta),
        .bus_abort (bus_abort),
        .clr_vec   (clr_vec),
        .status    (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= 1'b0;
        end else if (reg_wr_en) begin
            if (hit_mask) mask_q <= reg_wdata & IMPL;
            if (hit_enab) en_q   <= reg_wdata[0];
        end
    end

    assign pend = status & mask_q;
    assign fire = en_q && (|pend);

    evt_irq_prio u_prio (
        .pend  (pend),
        .idx   (vec_idx),
        .valid (vec_valid)
    );

    // interrupt line state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // next state: arm / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (fire)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!fire) state_d = IRQ_QUIET;
            default:               state_d = IRQ_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        irq_out = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  irq_out = 1'b0;
            IRQ_RAISED: irq_out = 1'b1;
            default:    irq_out = 1'b0;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        if (hit_stat) rd_mux = status;
        if (hit_mask) rd_mux = mask_q;
        if (hit_enab) rd_mux = {31'b0, en_q};
        if (hit_vect) begin
            rd_mux[4:0]     = vec_idx;
            rd_mux[VLD_BIT] = vec_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd_en;
            reg_rdata  <= reg_rd_en ? rd_mux : '0;
        end
    end

    // R6
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(en_q && (|pend)));

    // R8
    irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (|pend)) |=> irq_out);

    // R7
    en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |=> !irq_out);

    // R9
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (pend[vec_idx] && ((pend & ((32'h1 << vec_idx) - 32'h1)) == '0)));

    // R9
    vec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_idx == 5'd31 && pend == '0));

    // R10
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rvalid);

endmodule

// File: tb/evt_irq_hub_tb.sv
module evt_irq_hub_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [8:0]  desc_evt = '0;
    logic        ext_inta = 1'b0, bus_abort = 1'b0;
    logic        irq_out;
    logic [4:0]  vec_idx;
    logic        vec_valid;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .desc_evt(desc_evt), .ext_inta(ext_inta),
        .bus_abort(bus_abort), .irq_out(irq_out), .vec_idx(vec_idx), .vec_valid(vec_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_vec(input string tag, input logic v, input logic [4:0] i);
        check(tag, {26'b0, v, i}, {26'b0, v, i} ^ {26'b0, vec_valid ^ v, vec_idx ^ i});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset irq", {31'b0, irq_out}, 32'h0);
        check("R9 reset vec", {26'b0, vec_valid, vec_idx}, 32'h1F);
        do_read(12'h500, 32'h0, "R10 reset status");
        do_read(12'h504, 32'h0, "R10 reset mask");
        do_read(12'h508, 32'h0, "R10 reset enable");

        // R1 map every event
        desc_evt = 9'h1FF; bus_abort = 1'b1;
        @(negedge clk);
        desc_evt = '0; bus_abort = 1'b0;
        do_read(12'h500, 32'h040002FF, "R1 status map");
        do_read(12'h50C, 32'h0000001F, "R9 vector none");

        // R3 write-one-to-clear
        do_write(12'h500, 32'h0);
        do_read(12'h500, 32'h040002FF, "R3 zero write keeps");
        do_write(12'h500, 32'h00000105);
        do_read(12'h500, 32'h040002FA, "R3 clear bits 0 2 (R2 bit8)");

        // R6 enabled but masked
        do_write(12'h508, 32'h1);
        @(negedge clk);
        check("R6 masked no irq", {31'b0, irq_out}, 32'h0);
        check("R6 masked no vec", {31'b0, vec_valid}, 32'h0);

        // R8 unmask bit 9
        do_write(12'h504, 32'h00000200);
        check("R8 irq not yet", {31'b0, irq_out}, 32'h0);
        check("R9 vec bit9", {26'b0, vec_valid, vec_idx}, 32'h29);
        @(negedge clk);
        check("R8 irq raised", {31'b0, irq_out}, 32'h1);

        // R7 global disable
        do_write(12'h508, 32'h0);
        check("R8 irq still high", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R7 irq dropped", {31'b0, irq_out}, 32'h0);
        do_read(12'h500, 32'h040002FA, "R7 status kept");

        // R4 set wins over clear
        reg_wr_en = 1'b1; reg_addr = 12'h500; reg_wdata = 32'h2; desc_evt = 9'h002;
        @(negedge clk);
        reg_wr_en = 1'b0; desc_evt = '0;
        do_read(12'h500, 32'h040002FA, "R4 set wins");
        do_write(12'h500, 32'h2);
        do_read(12'h500, 32'h040002F8, "R3 clear bit1");

        // R5 level input
        ext_inta = 1'b1;
        repeat (2) @(negedge clk);
        do_read(12'h500, 32'h060002F8, "R5 ext set");
        do_write(12'h500, 32'h02000000);
        do_read(12'h500, 32'h060002F8, "R5 clear while high");
        ext_inta = 1'b0;
        do_write(12'h500, 32'h02000000);
        do_read(12'h500, 32'h040002F8, "R5 clear after low");

        // R2 / R9 mask all, walk the vector
        do_write(12'h504, 32'hFFFFFFFF);
        do_read(12'h504, 32'h060002FF, "R2 mask readback");
        do_write(12'h508, 32'h1);
        check("R9 vec bit3", {26'b0, vec_valid, vec_idx}, 32'h23);
        do_read(12'h50C, 32'h00000103, "R9 vector reg bit3");
        do_write(12'h500, 32'h000000F8);
        check("R9 vec bit9 again", {26'b0, vec_valid, vec_idx}, 32'h29);
        do_write(12'h500, 32'h00000200);
        check("R9 vec bit26", {26'b0, vec_valid, vec_idx}, 32'h3A);
        check("R6 irq on abort", {31'b0, irq_out}, 32'h1);
        do_write(12'h500, 32'hFFFFFFFF);
        check("R9 vec empty", {26'b0, vec_valid, vec_idx}, 32'h1F);
        check("R8 irq one more cycle", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R6 irq falls", {31'b0, irq_out}, 32'h0);

        // R10 unmapped offset, R2 enable width
        do_write(12'h510, 32'hFFFFFFFF);
        do_read(12'h510, 32'h0, "R10 unmapped read");
        do_read(12'h500, 32'h0, "R10 unmapped write ignored");
        do_write(12'h508, 32'hFFFFFFFE);
        do_read(12'h508, 32'h0, "R2 enable bit0 only");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R10 missing responses", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule